// File: doc/BRIEF.md
# Programmable-Timing Asynchronous Memory Bus Controller

This block sits between a simple valid/ready request port and an external asynchronous parallel memory bus with six chip selects. Each accepted request becomes one bus access: an optional bus-turnaround gap, an optional first-access latency, a read or write strobe, and, for writes, a hold period. Every chip select has its own 32-bit timing word, so slow flash, fast SRAM and peripherals with a page or burst start-up cost can share the same pins.

A configuration write port loads the six timing words and one enable word. A request that names a disabled chip select is answered with a done pulse and no bus activity. Read data is returned together with the done pulse. All bus pins come straight from flops.

Top module: `amem_bus_ctrl`

## Requirements
- R1: After reset all chip selects are disabled and every timing word is zero. Bus idle levels are: all `bus_cs_n` high, `bus_oe_n` and `bus_we_n` high, `bus_dout_en` low, `done` low, `req_ready` high. With zero timing an access is a one-cycle strobe with no latency.
- R2: The enable word uses bits 9:0. Chip select 0 owns bits 1:0, 1 owns bits 3:2, 2 owns bit 4, 3 owns bit 5, 4 owns bits 7:6 and 5 owns bits 9:8. A chip select is enabled when any of its bits is set. A request to a disabled chip select, or to an index of 6 or 7, asserts no chip select and gives `done` in the cycle after acceptance. At most one `bus_cs_n` bit is low at any time.
- R3: The timing word fields are: recovery in bits 31:28, write hold in 27:24, write latency in 23:16, read latency in 15:8, write wait in 7:4 and read wait in 3:0. A strobe lasts wait+1 cycles, using read wait for reads and write wait for writes. `bus_oe_n` is low only in read strobe cycles and `bus_we_n` only in write strobe cycles. The two are never low together.
- R4: After a write strobe the chip select stays low for write-hold more cycles, with `bus_we_n` high and write data still driven.
- R5: When the previous bus access was a read, recovery+1 cycles with no chip select asserted come before the new access. This applies if the new access targets another chip select, or if it is a write to the same one. The recovery value is taken from the timing word of the chip select that was read. No recovery is inserted otherwise.
- R6: The first access after reset, and any access to a chip select other than the last one used, first spends latency cycles with the chip select low and no strobe. The latency is the read or write latency field. Repeated accesses to the same chip select have no such cycles.
- R7: `req_ready` is low from the cycle after acceptance until the done cycle, in which it is high again. `done` is a one-cycle pulse in the cycle after the last bus cycle. In that cycle `rd_data` holds the `bus_din` value from the last read strobe cycle.
- R8: From the first chip-select cycle of an access to its last, `bus_addr` equals the request address. Whenever `bus_dout_en` is high, `bus_dout` equals the write data.
- R9: `cfg_sel` 0 to 5 writes the timing word of that chip select, 6 writes the enable word, and 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target: 0-5 timing word, 6 enable word |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip select index |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read data, valid with done |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Bus write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Bus read data |

## Verification
The bench builds the block with a 12-bit address and 16-bit data, so a read value can be derived from the address it answers. The timing counters always keep their full 8-bit and 4-bit widths. That lets the bench reach the 255-cycle latency and the 16-cycle strobe and recovery extremes in a short run. Chip selects are enabled through single bits from both halves of the two-bit groups. Disabled and out-of-range indices, a read after a write, a write after a read, and read-to-other-select sequences are all exercised back to back.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int NUM_CS = 6;
  localparam int CS_W   = 3;
  localparam int EN_W   = 10;
  localparam int CFG_W  = 32;
  localparam int CNT_W  = 8;
  localparam logic [CS_W-1:0] CS_MAX = 3'd5;
  localparam logic [CS_W-1:0] SEL_EN = 3'd6;

  // field order follows bit order of the timing word (msb first)
  typedef struct packed {
    logic [3:0] rec;
    logic [3:0] whold;
    logic [7:0] wlat;
    logic [7:0] rlat;
    logic [3:0] wwait;
    logic [3:0] rwait;
  } tword_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RECOV, PH_LAT, PH_STROBE, PH_HOLD
  } phase_t;

  function automatic logic [EN_W-1:0] en_mask(input int idx);
    case (idx)
      0:       return 10'b00_0000_0011;
      1:       return 10'b00_0000_1100;
      2:       return 10'b00_0001_0000;
      3:       return 10'b00_0010_0000;
      4:       return 10'b00_1100_0000;
      5:       return 10'b11_0000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/amem_cfg_regs.sv
module amem_cfg_regs
  import amem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [CS_W-1:0]   rd_idx,
  output tword_t            rd_word,
  output logic [EN_W-1:0]   en_bits
);
  logic [CFG_W-1:0] tw_mem [NUM_CS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CS; i++) tw_mem[i] <= '0;
    end else if (cfg_we && cfg_sel <= CS_MAX) begin
      tw_mem[cfg_sel] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_bits <= '0;
    else if (cfg_we && cfg_sel == SEL_EN) en_bits <= cfg_wdata[EN_W-1:0];
  end

  always_comb begin
    if (rd_idx <= CS_MAX) rd_word = tword_t'(tw_mem[rd_idx]);
    else                  rd_word = '0;
  end
endmodule

// File: rtl/amem_cs_enable.sv
module amem_cs_enable
  import amem_pkg::*;
(
  input  logic [EN_W-1:0]   en_bits,
  output logic [NUM_CS-1:0] cs_on
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_on[g] = |(en_bits & en_mask(g));
  end
endmodule

// File: rtl/amem_seq.sv
module amem_seq
  import amem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NUM_CS-1:0] cs_on,
  input  tword_t            tw_in,
  input  logic [DATA_W-1:0] bus_din,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en
);
  phase_t            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CS_W-1:0]   cs_q;
  logic              wr_q, first_q;
  tword_t            tw_q;
  logic              h_valid_q, h_rd_q;
  logic [CS_W-1:0]   h_cs_q;
  logic [3:0]        h_rec_q;

  logic              accept, done_n, cap;
  logic              sel_ok, need_rec, is_first;
  logic [CNT_W-1:0]  lat_in, wait_in, lat_q, wait_q;
  logic [CS_W-1:0]   cs_cur;
  logic              wr_cur, cs_act;

  assign sel_ok   = (req_cs <= CS_MAX) && cs_on[req_cs];
  assign need_rec = h_valid_q && h_rd_q && ((req_cs != h_cs_q) || req_write);
  assign is_first = !h_valid_q || (req_cs != h_cs_q);
  assign lat_in   = req_write ? tw_in.wlat : tw_in.rlat;
  assign wait_in  = CNT_W'(req_write ? tw_in.wwait : tw_in.rwait);
  assign lat_q    = wr_q ? tw_q.wlat : tw_q.rlat;
  assign wait_q   = CNT_W'(wr_q ? tw_q.wwait : tw_q.rwait);

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    cap     = 1'b0;
    accept  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (!sel_ok) begin
            done_n = 1'b1;
          end else begin
            accept = 1'b1;
            if (need_rec) begin
              phase_n = PH_RECOV;
              cnt_n   = CNT_W'(h_rec_q);
            end else if (is_first && lat_in != '0) begin
              phase_n = PH_LAT;
              cnt_n   = lat_in - 1'b1;
            end else begin
              phase_n = PH_STROBE;
              cnt_n   = wait_in;
            end
          end
        end
      end
      PH_RECOV: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else if (first_q && lat_q != '0) begin
          phase_n = PH_LAT;
          cnt_n   = lat_q - 1'b1;
        end else begin
          phase_n = PH_STROBE;
          cnt_n   = wait_q;
        end
      end
      PH_LAT: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else begin
          phase_n = PH_STROBE;
          cnt_n   = wait_q;
        end
      end
      PH_STROBE: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else begin
          cap = !wr_q;
          if (wr_q && tw_q.whold != '0) begin
            phase_n = PH_HOLD;
            cnt_n   = CNT_W'(tw_q.whold) - 1'b1;
          end else begin
            phase_n = PH_IDLE;
            done_n  = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else begin
          phase_n = PH_IDLE;
          done_n  = 1'b1;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  assign cs_cur = accept ? req_cs : cs_q;
  assign wr_cur = accept ? req_write : wr_q;
  assign cs_act = (phase_n == PH_LAT) || (phase_n == PH_STROBE) || (phase_n == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      cs_q      <= '0;
      wr_q      <= 1'b0;
      first_q   <= 1'b0;
      tw_q      <= '0;
      h_valid_q <= 1'b0;
      h_rd_q    <= 1'b0;
      h_cs_q    <= '0;
      h_rec_q   <= '0;
      bus_addr  <= '0;
      bus_dout  <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      if (accept) begin
        cs_q      <= req_cs;
        wr_q      <= req_write;
        first_q   <= is_first;
        tw_q      <= tw_in;
        h_valid_q <= 1'b1;
        h_rd_q    <= !req_write;
        h_cs_q    <= req_cs;
        h_rec_q   <= tw_in.rec;
        bus_addr  <= req_addr;
        if (req_write) bus_dout <= req_wdata;
      end
    end
  end

  // registered pins, decoded from the state being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready   <= 1'b1;
      done        <= 1'b0;
      rd_data     <= '0;
      bus_cs_n    <= '1;
      bus_oe_n    <= 1'b1;
      bus_we_n    <= 1'b1;
      bus_dout_en <= 1'b0;
    end else begin
      req_ready <= (phase_n == PH_IDLE);
      done      <= done_n;
      if (cap) rd_data <= bus_din;
      for (int i = 0; i < NUM_CS; i++)
        bus_cs_n[i] <= !(cs_act && (cs_cur == CS_W'(i)));
      bus_oe_n    <= !((phase_n == PH_STROBE) && !wr_cur);
      bus_we_n    <= !((phase_n == PH_STROBE) && wr_cur);
      bus_dout_en <= wr_cur && ((phase_n == PH_STROBE) || (phase_n == PH_HOLD));
    end
  end
endmodule

// File: rtl/amem_bus_ctrl.sv
module amem_bus_ctrl
  import amem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [5:0]        bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din
);
  tword_t            tw_sel;
  logic [EN_W-1:0]   en_bits;
  logic [NUM_CS-1:0] cs_on;

  amem_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_idx(req_cs), .rd_word(tw_sel), .en_bits(en_bits)
  );

  amem_cs_enable u_en (.en_bits(en_bits), .cs_on(cs_on));

  amem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .cs_on(cs_on), .tw_in(tw_sel), .bus_din(bus_din),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
  );
endmodule

// File: rtl/amem_bus_ctrl_chk.sv
module amem_bus_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic [5:0]        bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_we_n,
  input logic              bus_dout_en,
  input logic [ADDR_W-1:0] bus_addr
);
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));

  assert_oe_we_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n));

  assert_strobe_has_cs_R3: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n || !bus_we_n) |-> (bus_cs_n != 6'h3f));

  assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> bus_oe_n);

  assert_we_with_data_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> bus_dout_en);

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready || done));

  assert_done_ready_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));
endmodule

bind amem_bus_ctrl amem_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
  .bus_dout_en(bus_dout_en), .bus_addr(bus_addr)
);

// File: tb/amem_bus_ctrl_bench.sv
module amem_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [2:0]    req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done;
  logic [DW-1:0] rd_data;
  logic [5:0]    bus_cs_n;
  logic          bus_oe_n, bus_we_n, bus_dout_en;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: read data is a fixed function of the address
  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a, 4'b0101} ^ 16'hC3A5;
  endfunction
  assign bus_din = mem_val(bus_addr);

  amem_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_amem_bus_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din)
  );

  typedef struct packed {
    logic [5:0]    csn;
    logic          oen, wen, den, dn, rdy;
    logic          ca;
    logic [AW-1:0] a;
    logic          cd;
    logic [DW-1:0] d;
    logic          cr;
    logic [DW-1:0] r;
    logic [3:0]    tag;
  } ent_t;

  function automatic string rname(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [9:0] bench_mask(input int c);
    case (c)
      0: return 10'h003;
      1: return 10'h00c;
      2: return 10'h010;
      3: return 10'h020;
      4: return 10'h0c0;
      5: return 10'h300;
      default: return 10'h000;
    endcase
  endfunction

  function automatic ent_t mk(input logic [5:0] csn, input logic oen, wen, den, dn, rdy,
                              input logic [3:0] tag);
    ent_t e;
    e = '0;
    e.csn = csn; e.oen = oen; e.wen = wen; e.den = den; e.dn = dn; e.rdy = rdy;
    e.tag = tag;
    return e;
  endfunction

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  ent_t q[$];
  ent_t cur;
  logic [31:0] m_tw [6];
  logic [9:0]  m_en;
  bit          h_valid, h_rd;
  int          h_cs, h_rec;

  task automatic build(input logic wr, input int cs, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    ent_t e;
    logic [31:0] t;
    int rec, wh, lat, wt;
    bit need, first;
    logic [5:0] low;
    if (cs > 5 || (m_en & bench_mask(cs)) == 0) begin
      q.push_back(mk(6'h3f, 1, 1, 0, 1, 1, 4'd2));
      return;
    end
    t   = m_tw[cs];
    rec = int'(t[31:28]);
    wh  = int'(t[27:24]);
    lat = wr ? int'(t[23:16]) : int'(t[15:8]);
    wt  = wr ? int'(t[7:4]) : int'(t[3:0]);
    need  = h_valid && h_rd && (cs != h_cs || wr);
    first = !h_valid || cs != h_cs;
    low   = ~(6'b1 << cs);
    if (need) for (int i = 0; i <= h_rec; i++) q.push_back(mk(6'h3f, 1, 1, 0, 0, 0, 4'd5));
    if (first) for (int i = 0; i < lat; i++) begin
      e = mk(low, 1, 1, 0, 0, 0, 4'd6); e.ca = 1; e.a = a; q.push_back(e);
    end
    for (int i = 0; i <= wt; i++) begin
      e = mk(low, wr, !wr, wr, 0, 0, 4'd3); e.ca = 1; e.a = a; e.cd = wr; e.d = d;
      q.push_back(e);
    end
    if (wr) for (int i = 0; i < wh; i++) begin
      e = mk(low, 1, 1, 1, 0, 0, 4'd4); e.ca = 1; e.a = a; e.cd = 1; e.d = d;
      q.push_back(e);
    end
    e = mk(6'h3f, 1, 1, 0, 1, 1, 4'd7); e.cr = !wr; e.r = mem_val(a);
    q.push_back(e);
    h_valid = 1; h_rd = !wr; h_cs = cs; h_rec = rec;
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      for (int i = 0; i < 6; i++) m_tw[i] = '0;
      m_en = '0; h_valid = 0; h_rd = 0; h_cs = 0; h_rec = 0;
      cur = mk(6'h3f, 1, 1, 0, 0, 1, 4'd1);
    end else begin
      if (req_valid && cur.rdy) build(req_write, int'(req_cs), req_addr, req_wdata);
      if (cfg_we) begin
        if (cfg_sel <= 3'd5) m_tw[cfg_sel] = cfg_wdata;
        else if (cfg_sel == 3'd6) m_en = cfg_wdata[9:0];
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = mk(6'h3f, 1, 1, 0, 0, 1, 4'd1);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      total++;
      if ({bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en, done, req_ready} !==
          {cur.csn, cur.oen, cur.wen, cur.den, cur.dn, cur.rdy}) begin
        bad++;
        $display("FAIL %s ctrl act=%b exp=%b", rname(cur.tag),
                 {bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en, done, req_ready},
                 {cur.csn, cur.oen, cur.wen, cur.den, cur.dn, cur.rdy});
      end
      if (cur.ca) begin
        total++;
        if (bus_addr !== cur.a) begin
          bad++; $display("FAIL R8 addr act=%h exp=%h", bus_addr, cur.a);
        end
      end
      if (cur.cd) begin
        total++;
        if (bus_dout !== cur.d) begin
          bad++; $display("FAIL R8 dout act=%h exp=%h", bus_dout, cur.d);
        end
      end
      if (cur.cr) begin
        total++;
        if (rd_data !== cur.r) begin
          bad++; $display("FAIL R7 rd_data act=%h exp=%h", rd_data, cur.r);
        end
      end
    end
  end

  task automatic cfg(input logic [2:0] sel, input logic [31:0] val);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic do_req(input logic wr, input logic [2:0] cs, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
    req_valid = 1; req_write = wr; req_cs = cs; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
  endtask

  function automatic logic [31:0] tw(input int rec, wh, wl, rl, ww, rw);
    return {4'(rec), 4'(wh), 8'(wl), 8'(rl), 4'(ww), 4'(rw)};
  endfunction

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL R7 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);                 // R1 idle levels
    do_req(0, 3'd0, 12'h010, '0);              // R1 R2: nothing enabled after reset
    cfg(3'd6, 32'h0000_0112);                  // R2: cs0 bit1, cs2 bit4, cs5 bit8
    cfg(3'd0, tw(2, 3, 4, 2, 1, 3));
    cfg(3'd5, tw(15, 0, 9, 255, 0, 15));
    do_req(0, 3'd0, 12'h123, '0);              // R6 latency 2, R3 strobe 4
    do_req(0, 3'd0, 12'h124, '0);              // R6 no latency on repeat, R5 none
    do_req(1, 3'd0, 12'h200, 16'hBEEF);        // R5 recovery 3, R4 hold 3
    do_req(1, 3'd0, 12'h201, 16'h1234);        // R5 none after write
    do_req(0, 3'd2, 12'h3A0, '0);              // R1 zero timing, R6 zero latency
    do_req(0, 3'd5, 12'h7FF, '0);              // R5 from cs2 rec 0, R6 255, R3 16
    do_req(1, 3'd5, 12'h7FE, 16'hA5A5);        // R5 recovery 16, write same cs
    do_req(0, 3'd1, 12'h001, '0);              // R2 disabled
    do_req(0, 3'd6, 12'h002, '0);              // R2 index out of range
    do_req(1, 3'd7, 12'h003, 16'h0F0F);        // R2 index out of range
    cfg(3'd7, 32'hFFFF_FFFF);                  // R9: select 7 ignored
    do_req(0, 3'd3, 12'h044, '0);              // R9: cs3 still disabled
    cfg(3'd6, 32'h0000_0172);                  // R2: add cs3 bit5, cs4 bit6
    do_req(0, 3'd3, 12'h045, '0);              // R2 single-bit enable
    do_req(1, 3'd4, 12'h046, 16'h5555);        // R5 read cs3 then cs4
    do_req(0, 3'd4, 12'h047, '0);              // R3 read after write same cs
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule